// File: doc/BRIEF.md
# SPI Master with Late-Sample Transfer Option

This block is an SPI bus master for clock-polarity 0, clock-phase 1 transfers. A host hands it one frame at a time on a valid/ready input. Each frame carries up to 16 data bits, a bit count, a mask of chip-select lines to drive, and a continue flag. The block asserts the chosen selects and waits a programmable lead time. It then toggles SCK from a divided system clock, shifts the frame out MSB first on MOSI and collects the same number of bits from MISO. The result comes back with a one-cycle done pulse.

Sampling has two options. In standard mode the master samples MISO on every falling SCK edge. In late-sample mode it samples on rising edges, starting with the second rising edge. It takes the final bit half an SCK period after the last falling edge, and no SCK transition is produced for that sample. This gives a slow slave a full SCK period to answer. Each select line has its own idle level.

After the last edge a programmable trail time runs. The selects then either return to idle or, when the frame asked to continue, stay asserted. In the continue case the next frame starts without the lead delay. Divider, delays and mode are captured when a frame is accepted.

Top module: `spi_mfmt_master`

## Requirements
- R1: When a frame is accepted from idle, each line set in `frm_sel` is driven to the inverse of its `cfg_cs_idle` bit from the next cycle on, and the other lines stay at idle. The first rising SCK edge follows the select assertion after `cfg_csc` system clocks (0 counts as 1). The selects do not change while the frame runs.
- R2: SCK idles low. An N-bit frame produces exactly 2N SCK edges, spaced `cfg_half` system clocks apart (0 counts as 1; a value of 2 gives SCK at one quarter of the system clock).
- R3: MOSI presents bit N-1 of `frm_data` first and steps to the next lower bit at every rising SCK edge. Each bit is therefore stable across the following falling edge. MOSI changes at no other time during the frame.
- R4: With `cfg_mod`=0 the master samples MISO at each falling edge. `rx_valid` rises in the cycle in which SCK falls for the 2N-th edge.
- R5: With `cfg_mod`=1 the master samples MISO at each rising edge from the second one on. It takes the final bit `cfg_half` clocks after the last falling edge, with no SCK transition at that time. `rx_valid` rises with that sample.
- R6: `rx_valid` is high for exactly one cycle per frame. `rx_data` then holds the N received bits, first-received bit most significant, right-aligned, with zeros above.
- R7: `frm_len` below 4 is treated as 4 and above 16 as 16.
- R8: The trail time runs from the last SCK edge and lasts `cfg_asc` clocks. It is raised to at least 1, and in late-sample mode to at least the half period. When the frame's continue flag is 0, the selects return to idle at the end of the trail.
- R9: While idle, every select line follows its `cfg_cs_idle` bit, starting the cycle after a change. After reset the lines sit at those levels, with SCK, MOSI and `rx_valid` low.
- R10: When the continue flag is 1, the selects stay asserted after the trail. A following frame is accepted with no lead delay: its first rising edge comes one clock after acceptance.
- R11: `frm_ready` is high only when idle or holding after a continued frame. A frame is taken when `frm_valid` and `frm_ready` are both high. While `frm_valid` is low, the block stays idle with SCK low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mod | input | 1 | 1 selects late-sample mode |
| cfg_half | input | 8 | SCK half period in system clocks |
| cfg_csc | input | 8 | Select-to-first-edge delay in system clocks |
| cfg_asc | input | 8 | Last-edge-to-deselect delay in system clocks |
| cfg_cs_idle | input | 4 | Idle level of each select line |
| frm_valid | input | 1 | Frame offered |
| frm_ready | output | 1 | Frame can be taken |
| frm_data | input | 16 | Transmit bits, right-aligned |
| frm_len | input | 5 | Bits in the frame |
| frm_sel | input | 4 | Select lines to assert |
| frm_cont | input | 1 | Keep selects asserted after this frame |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Select lines |
| rx_valid | output | 1 | One-cycle done pulse |
| rx_data | output | 16 | Received bits, right-aligned |

## Verification
The bench builds the block with its default parameters: 16-bit frames, a 4-bit minimum, four select lines and 8-bit divider and delay fields. It draws half periods from 0 to 4, which reaches the divide-by-2 and divide-by-4 SCK rates as well as the "0 counts as 1" case. It draws lead and trail values from 0 to 6, so the late-sample trail floor lands both above and below the programmed trail. Frame lengths run from 2 to 20, so both clamps are reached, and chains of continued frames exercise the lead skip.

// File: rtl/spi_mfmt_pkg.sv
package spi_mfmt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL,
    ST_HOLD
  } spi_st_e;
endpackage

// File: rtl/spi_mfmt_timer.sv
// Shared phase timer: counts system clocks, restarts on clr, flags the last
// cycle of a programmed limit.
module spi_mfmt_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [TW-1:0] lim,
  output logic [TW-1:0] cnt_o,
  output logic          hit_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + TW'(1);
  end

  assign cnt_o = cnt_q;
  assign hit_o = (cnt_q == lim - TW'(1));

  // Edge spacing relies on the count never passing its limit.
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    !clr |-> (cnt_q < lim));
endmodule

// File: rtl/spi_mfmt_shift.sv
// Transmit and receive shift registers with the registered MOSI pin.
module spi_mfmt_shift #(
  parameter int MAXB = 16,
  parameter int LW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MAXB-1:0] ld_data,
  input  logic [LW-1:0]   ld_len,
  input  logic            drv_first,
  input  logic            drv_next,
  input  logic            park,
  input  logic            samp,
  input  logic            last,
  input  logic            miso,
  output logic            mosi,
  output logic            rx_valid,
  output logic [MAXB-1:0] rx_data
);
  logic [MAXB-1:0] tx_q, rx_q;
  logic [LW-1:0]   sh_amt;
  logic            mosi_q, rxv_q;
  logic [MAXB-1:0] rxd_q;

  assign sh_amt = LW'(MAXB) - ld_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      tx_q <= ld_data << sh_amt;
    end else if (drv_first) begin
      mosi_q <= tx_q[MAXB-1];
    end else if (drv_next) begin
      mosi_q <= tx_q[MAXB-2];
      tx_q   <= tx_q << 1;
    end else if (park) begin
      mosi_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q  <= '0;
      rxv_q <= 1'b0;
      rxd_q <= '0;
    end else begin
      rxv_q <= last;
      if (load)      rx_q <= '0;
      else if (samp) rx_q <= {rx_q[MAXB-2:0], miso};
      if (last)      rxd_q <= {rx_q[MAXB-2:0], miso};
    end
  end

  assign mosi     = mosi_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;

  assert_last_is_sample_R6: assert property (@(posedge clk) disable iff (rst)
    last |-> samp);
  assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!drv_first && !drv_next && !park) |=> $stable(mosi));
endmodule

// File: rtl/spi_mfmt_csel.sv
// Per-line select drivers with individual idle levels.
module spi_mfmt_csel #(
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCS-1:0] idle_lvl,
  input  logic           set,
  input  logic [NCS-1:0] sel,
  input  logic           rel,
  output logic [NCS-1:0] cs_o
);
  logic [NCS-1:0] cs_q;

  for (genvar i = 0; i < NCS; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)      cs_q[i] <= idle_lvl[i];
      else if (set) cs_q[i] <= sel[i] ? ~idle_lvl[i] : idle_lvl[i];
      else if (rel) cs_q[i] <= idle_lvl[i];
    end
  end

  assign cs_o = cs_q;

  assert_cs_release_R9: assert property (@(posedge clk) disable iff (rst)
    (rel && !set) |=> (cs_o == $past(idle_lvl)));
endmodule

// File: rtl/spi_mfmt_master.sv
module spi_mfmt_master #(
  parameter int MAX_BITS = 16,
  parameter int MIN_BITS = 4,
  parameter int NCS      = 4,
  parameter int HW       = 8,
  parameter int DW       = 8,
  localparam int LW      = $clog2(MAX_BITS + 1),
  localparam int TW      = (HW > DW) ? HW : DW,
  localparam int EW      = $clog2(2 * MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_mod,
  input  logic [HW-1:0]       cfg_half,
  input  logic [DW-1:0]       cfg_csc,
  input  logic [DW-1:0]       cfg_asc,
  input  logic [NCS-1:0]      cfg_cs_idle,
  input  logic                frm_valid,
  output logic                frm_ready,
  input  logic [MAX_BITS-1:0] frm_data,
  input  logic [LW-1:0]       frm_len,
  input  logic [NCS-1:0]      frm_sel,
  input  logic                frm_cont,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic [NCS-1:0]      cs_o,
  output logic                rx_valid,
  output logic [MAX_BITS-1:0] rx_data
);
  import spi_mfmt_pkg::*;

  spi_st_e       st;
  logic          ready_q, sck_q, mod_q, cont_q;
  logic [LW-1:0] len_q, len_c;
  logic [TW-1:0] half_q, asc_q, lead_q;
  logic [TW-1:0] half_c, csc_c, asc_c, asc_floor;
  logic [EW-1:0] edge_q, e_next, two_n;
  logic [TW-1:0] t_lim, t_cnt;
  logic          t_hit, t_clr, busy;
  logic          accept, tick, phantom, trail_end;
  logic          drv_first, drv_next, samp, last, park, cs_rel;

  // ---------------- frame capture arithmetic ----------------
  assign accept = frm_valid && ready_q;

  always_comb begin
    if (frm_len < LW'(MIN_BITS))      len_c = LW'(MIN_BITS);
    else if (frm_len > LW'(MAX_BITS)) len_c = LW'(MAX_BITS);
    else                              len_c = frm_len;
  end

  always_comb begin
    half_c    = (cfg_half == '0) ? TW'(1) : TW'(cfg_half);
    csc_c     = (cfg_csc == '0)  ? TW'(1) : TW'(cfg_csc);
    asc_floor = cfg_mod ? half_c : TW'(1);
    asc_c     = (TW'(cfg_asc) < asc_floor) ? asc_floor : TW'(cfg_asc);
  end

  // ---------------- phase timer ----------------
  assign busy = (st == ST_LEAD) || (st == ST_XFER) || (st == ST_TRAIL);

  always_comb begin
    case (st)
      ST_LEAD:  t_lim = lead_q;
      ST_XFER:  t_lim = half_q;
      ST_TRAIL: t_lim = asc_q;
      default:  t_lim = TW'(1);
    endcase
  end

  assign t_clr = !busy || t_hit;

  spi_mfmt_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (t_clr),
    .lim   (t_lim),
    .cnt_o (t_cnt),
    .hit_o (t_hit)
  );

  // ---------------- edge bookkeeping ----------------
  assign two_n     = EW'(len_q) << 1;
  assign e_next    = edge_q + EW'(1);
  assign tick      = (st == ST_XFER) && t_hit;
  assign trail_end = (st == ST_TRAIL) && t_hit;
  assign phantom   = (st == ST_TRAIL) && mod_q && (t_cnt == half_q - TW'(1));

  assign drv_first = (st == ST_LEAD) && t_hit;
  assign drv_next  = tick && e_next[0];
  assign samp      = (tick && (e_next[0] ? mod_q : !mod_q)) || phantom;
  assign last      = (tick && !mod_q && (e_next == two_n)) || phantom;
  assign park      = trail_end && !cont_q;
  assign cs_rel    = (st == ST_IDLE) || park;

  // ---------------- control state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ready_q <= 1'b1;
      sck_q   <= 1'b0;
      edge_q  <= '0;
      len_q   <= LW'(MIN_BITS);
      mod_q   <= 1'b0;
      cont_q  <= 1'b0;
      half_q  <= TW'(1);
      asc_q   <= TW'(1);
      lead_q  <= TW'(1);
    end else begin
      case (st)
        ST_IDLE, ST_HOLD: begin
          if (accept) begin
            st      <= ST_LEAD;
            ready_q <= 1'b0;
            len_q   <= len_c;
            mod_q   <= cfg_mod;
            cont_q  <= frm_cont;
            half_q  <= half_c;
            asc_q   <= asc_c;
            lead_q  <= (st == ST_HOLD) ? TW'(1) : csc_c;
          end
        end
        ST_LEAD: begin
          if (t_hit) begin
            st     <= ST_XFER;
            sck_q  <= 1'b1;
            edge_q <= EW'(1);
          end
        end
        ST_XFER: begin
          if (t_hit) begin
            edge_q <= e_next;
            sck_q  <= e_next[0];
            if (e_next == two_n) st <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (t_hit) begin
            ready_q <= 1'b1;
            st      <= cont_q ? ST_HOLD : ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign frm_ready = ready_q;
  assign sck       = sck_q;

  // ---------------- datapath and selects ----------------
  spi_mfmt_shift #(.MAXB(MAX_BITS), .LW(LW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .ld_data   (frm_data),
    .ld_len    (len_c),
    .drv_first (drv_first),
    .drv_next  (drv_next),
    .park      (park),
    .samp      (samp),
    .last      (last),
    .miso      (miso),
    .mosi      (mosi),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data)
  );

  spi_mfmt_csel #(.NCS(NCS)) u_csel (
    .clk      (clk),
    .rst      (rst),
    .idle_lvl (cfg_cs_idle),
    .set      (accept),
    .sel      (frm_sel),
    .rel      (cs_rel),
    .cs_o     (cs_o)
  );

  // ---------------- assertions ----------------
  assert_sck_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE || st == ST_HOLD || st == ST_LEAD) |-> !sck);
  assert_no_trail_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TRAIL) |-> !sck);
  assert_cs_stable_xfer_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER) |=> $stable(cs_o));
  assert_accept_ready_R11: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_ready) |=> (st == ST_LEAD) && !frm_ready);
  assert_len_range_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (len_q >= LW'(MIN_BITS)) && (len_q <= LW'(MAX_BITS)));
  assert_asc_floor_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && mod_q) |-> (asc_q >= half_q));
endmodule

// File: tb/spi_mfmt_master_bench.sv
module spi_mfmt_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_mod = 1'b0;
  logic [7:0]  cfg_half = 8'd2, cfg_csc = 8'd1, cfg_asc = 8'd1;
  logic [3:0]  cfg_cs_idle = 4'b1010;
  logic        frm_valid = 1'b0, frm_cont = 1'b0;
  logic [15:0] frm_data = '0;
  logic [4:0]  frm_len = 5'd8;
  logic [3:0]  frm_sel = '0;
  logic        miso = 1'b0;
  logic        frm_ready, sck, mosi, rx_valid;
  logic [3:0]  cs_o;
  logic [15:0] rx_data;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit in_hold = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_mfmt_master u_spi_mfmt_master (
    .clk(clk), .rst(rst), .cfg_mod(cfg_mod), .cfg_half(cfg_half),
    .cfg_csc(cfg_csc), .cfg_asc(cfg_asc), .cfg_cs_idle(cfg_cs_idle),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data),
    .frm_len(frm_len), .frm_sel(frm_sel), .frm_cont(frm_cont),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_o(cs_o),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp_len(input int l);
    if (l < 4) return 4;
    if (l > 16) return 16;
    return l;
  endfunction

  function automatic int eff1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run_frame(input logic [15:0] data, input int len_in,
                           input logic [3:0] sel, input bit cont,
                           input logic [15:0] sw);
    int n, half_e, lead_e, asc_e, a, t_first, t_prev, t_last, end_t;
    int edges, nb, rxv_cnt, rxv_t, guard;
    bit prev, bad_space, cs_bad, hold_at_start;
    logic [15:0] mw, rx_got, mask;
    logic [3:0] act, idl;
    n = clamp_len(len_in);
    mask = 16'((32'd1 << n) - 1);
    half_e = eff1(int'(cfg_half));
    hold_at_start = in_hold;
    lead_e = hold_at_start ? 1 : eff1(int'(cfg_csc));
    asc_e = int'(cfg_asc);
    if (cfg_mod) begin if (asc_e < half_e) asc_e = half_e; end
    else if (asc_e < 1) asc_e = 1;
    idl = cfg_cs_idle;
    act = idl ^ sel;
    t_first = -1; t_prev = -1; t_last = -1; end_t = -1;
    edges = 0; nb = 0; rxv_cnt = 0; rxv_t = -1; guard = 0;
    prev = 0; bad_space = 0; cs_bad = 0; mw = '0; rx_got = '0;

    frm_data = data; frm_len = 5'(len_in); frm_sel = sel; frm_cont = cont;
    frm_valid = 1'b1;
    while (!frm_ready && guard < 5000) begin @(negedge clk); guard++; end
    a = cyc + 1;
    @(negedge clk);
    frm_valid = 1'b0;
    chk(cs_o == act, "R1", "selects asserted after accept", cs_o, act);
    chk(!frm_ready, "R11", "ready low once frame taken", frm_ready, 0);
    guard = 0;
    forever begin
      if (sck && !prev) begin
        edges++;
        if (t_first < 0) t_first = cyc;
        else if (cyc - t_prev != half_e) bad_space = 1;
        t_prev = cyc;
        if (nb < n) miso = sw[n-1-nb];
        nb++;
      end else if (!sck && prev) begin
        edges++;
        if (cyc - t_prev != half_e) bad_space = 1;
        t_prev = cyc;
        t_last = cyc;
        mw = {mw[14:0], mosi};
      end
      if (rx_valid) begin rxv_cnt++; rxv_t = cyc; rx_got = rx_data; end
      if (frm_ready) begin end_t = cyc; break; end
      if (cs_o != act) cs_bad = 1;
      prev = sck;
      @(negedge clk);
      guard++;
      if (guard > 5000) begin
        chk(0, "R11", "frame never finished", guard, 0);
        break;
      end
    end
    chk(t_first - a == lead_e, hold_at_start ? "R10" : "R1",
        "lead from accept to first rise", t_first - a, lead_e);
    chk(edges == 2 * n, "R2", "edge count", edges, 2 * n);
    chk(!bad_space, "R2", "edge spacing", bad_space, 0);
    chk(!cs_bad, "R1", "selects steady during frame", cs_bad, 0);
    chk((mw & mask) == (data & mask), "R3", "bits seen on MOSI",
        mw & mask, data & mask);
    chk(rxv_cnt == 1, "R6", "done pulse count", rxv_cnt, 1);
    if (cfg_mod)
      chk(rxv_t == t_last + half_e, "R5", "late final sample timing",
          rxv_t - t_last, half_e);
    else
      chk(rxv_t == t_last, "R4", "done at last falling edge",
          rxv_t - t_last, 0);
    chk(rx_got == (sw & mask), cfg_mod ? "R5" : "R4", "received word",
        rx_got, sw & mask);
    chk(end_t - t_last == asc_e, "R8", "trail length", end_t - t_last, asc_e);
    if (cont)
      chk(cs_o == act, "R10", "selects held after continued frame", cs_o, act);
    else
      chk(cs_o == idl, "R8", "selects back to idle", cs_o, idl);
    if (n != len_in)
      chk(edges == 2 * n, "R7", "clamped length", edges / 2, n);
    in_hold = cont;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_o == 4'b1010, "R9", "select levels after reset", cs_o, 4'b1010);
    chk({sck, mosi, rx_valid} == 3'b000, "R9", "pins quiet after reset",
        {sck, mosi, rx_valid}, 0);
    chk(frm_ready, "R11", "ready after reset", frm_ready, 1);
    cfg_cs_idle = 4'b0110;
    @(negedge clk);
    chk(cs_o == 4'b0110, "R9", "selects follow idle levels", cs_o, 4'b0110);
    repeat (5) @(negedge clk);
    chk(!sck && frm_ready && cs_o == 4'b0110, "R11",
        "stays idle without valid", sck, 0);

    // Directed: standard mode, quarter-rate SCK
    cfg_mod = 0; cfg_half = 2; cfg_csc = 2; cfg_asc = 1;
    run_frame(16'h00A5, 8, 4'b0001, 0, 16'h005C);
    // Directed: late-sample, full width, trail floor raised to half period
    cfg_mod = 1; cfg_half = 2; cfg_csc = 0; cfg_asc = 0;
    run_frame(16'hBEEF, 16, 4'b1000, 0, 16'h1234);
    // Directed: length clamps
    cfg_half = 3; cfg_asc = 7;
    run_frame(16'h0005, 3, 4'b0100, 0, 16'h000B);
    run_frame(16'hC3A5, 20, 4'b0010, 0, 16'h8E71);
    // Directed: continued chain, divide-by-2 SCK, half period 0
    cfg_half = 0; cfg_asc = 5; cfg_csc = 4;
    run_frame(16'h0009, 4, 4'b0011, 1, 16'h0006);
    cfg_mod = 0;
    run_frame(16'h0F0F, 12, 4'b0011, 1, 16'h0ABC);
    run_frame(16'h00FF, 9, 4'b0001, 0, 16'h0155);

    // Random frames
    for (int i = 0; i < 40; i++) begin
      cfg_mod  = 1'($urandom_range(0, 1));
      cfg_half = 8'($urandom_range(0, 4));
      cfg_csc  = 8'($urandom_range(0, 6));
      cfg_asc  = 8'($urandom_range(0, 6));
      if (!in_hold) cfg_cs_idle = 4'($urandom_range(0, 15));
      run_frame(16'($urandom), $urandom_range(2, 20),
                4'($urandom_range(1, 15)), 1'($urandom_range(0, 1)),
                16'($urandom));
    end
    if (in_hold) run_frame(16'h1357, 6, 4'b0100, 0, 16'h002A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule